// File: doc/BRIEF.md
# Bus-Cycle Break Condition Matcher

This block watches a processor bus one cycle at a time. It raises a break request when the current cycle matches a programmed set of conditions. Four attributes of each cycle are checked: which master owns the bus (the CPU or a peripheral master such as DMA), whether the cycle is an instruction fetch or a data access, its direction, and its operand size. The cycle address must also equal a compare value in every bit that a mask leaves enabled. Software programs an 8-bit condition byte, a compare word and a mask word through a small write-only register port.

Each attribute field is a two-bit select, and each bit of it admits one kind of cycle. If the owner, fetch/data or direction field is zero, the channel is disabled. If the size field is zero, size is not checked. The match is evaluated only while the cycle strobe is high, and the result is registered. In the clock after a matching cycle, a sticky flag is set. In that same clock a one-cycle interrupt pulse is driven, but only if the flag was clear. Software clears the flag by writing 0 to it.

Top module: `bus_break_matcher`

## Requirements
- R1: After reset the condition byte, compare word and mask word are all zero, `brk_flag` and `brk_irq` are low, and no cycle can raise a break.
- R2: Register port (`reg_sel`): 0 = condition byte in `reg_wdata[7:0]`, 1 = compare word, 2 = mask word, 3 = flag control. The condition byte layout is: owner field in bits 7:6, fetch/data field in bits 5:4, direction field in bits 3:2, size field in bits 1:0. In the owner field, bit 6 admits CPU cycles (`cyc_periph`=0) and bit 7 admits peripheral cycles (`cyc_periph`=1). A value of 00 never matches.
- R3: In the fetch/data field, bit 4 admits instruction fetches (`cyc_fetch`=1) and bit 5 admits data accesses. A value of 00 never matches.
- R4: In the direction field, bit 2 admits reads (`cyc_write`=0) and bit 3 admits writes. A value of 00 never matches.
- R5: The size field is compared with `cyc_size`, which is encoded 01 = byte, 10 = word, 11 = longword. A size field of 00 means size is not checked. Any other value must equal the cycle's effective size.
- R6: An instruction fetch always counts as a word access, whatever `cyc_size` says. A size field of 01 therefore never matches a fetch cycle.
- R7: `cyc_addr` must equal the compare word in every bit where the mask word holds 0. Address bits where the mask holds 1 are ignored.
- R8: A cycle is evaluated only when `cyc_valid` is high. When `cyc_valid` is low, nothing is set or pulsed.
- R9: A matching cycle sets `brk_flag` in the next clock. If `brk_flag` was clear, the block also drives `brk_irq` high for exactly that one clock. Further matches while the flag is set give no pulse.
- R10: Writing `reg_sel`=3 with `reg_wdata[0]`=0 clears the flag. Writing with bit 0 = 1 has no effect. A match in the same cycle as a clear takes precedence and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | ADDR_W | Register write data |
| cyc_valid | input | 1 | Bus cycle attributes are valid this clock |
| cyc_periph | input | 1 | 1 = peripheral master, 0 = CPU |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_size | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| cyc_addr | input | ADDR_W | Cycle address |
| brk_flag | output | 1 | Sticky break flag |
| brk_irq | output | 1 | One-cycle break interrupt pulse |

## Verification
The assertions check on every cycle the relations between the flag, the pulse, the strobe and the condition byte. A pulse always comes with the flag set and never repeats in the next clock. A pulse needs a valid cycle and non-zero enable fields, and never follows a fetch when byte size is selected. The flag rises only with a pulse and falls only after a clear write. Whether the right cycles match can only be shown by the bench's scenarios. These cover the full sweep of every condition byte against every attribute combination, the masked address comparison, and the clear-versus-match race.

// File: rtl/bus_break_matcher.sv
module bus_break_matcher #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              cyc_valid,
  input  logic              cyc_periph,
  input  logic              cyc_fetch,
  input  logic              cyc_write,
  input  logic [1:0]        cyc_size,
  input  logic [ADDR_W-1:0] cyc_addr,
  output logic              brk_flag,
  output logic              brk_irq
);
  localparam logic [1:0] SZ_WORD = 2'b10;

  logic [7:0]        ctl_q;
  logic [ADDR_W-1:0] cmp_q, msk_q;
  logic              flag_q, irq_q;

  wire [1:0] owner_f = ctl_q[7:6];
  wire [1:0] kind_f  = ctl_q[5:4];
  wire [1:0] dir_f   = ctl_q[3:2];
  wire [1:0] size_f  = ctl_q[1:0];

  wire       owner_ok = cyc_periph ? owner_f[1] : owner_f[0];
  wire       kind_ok  = cyc_fetch  ? kind_f[0]  : kind_f[1];
  wire       dir_ok   = cyc_write  ? dir_f[1]   : dir_f[0];
  wire [1:0] eff_size = cyc_fetch  ? SZ_WORD    : cyc_size;
  wire       size_ok  = (size_f == 2'b00) || (size_f == eff_size);
  wire       addr_ok  = ((cyc_addr ^ cmp_q) & ~msk_q) == '0;

  wire hit   = cyc_valid && owner_ok && kind_ok && dir_ok && size_ok && addr_ok;
  wire clear = reg_we && (reg_sel == 2'd3) && !reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '0;
      msk_q <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0:    ctl_q <= reg_wdata[7:0];
        2'd1:    cmp_q <= reg_wdata;
        2'd2:    msk_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit && !flag_q;
      if (hit)        flag_q <= 1'b1;
      else if (clear) flag_q <= 1'b0;
    end
  end

  assign brk_flag = flag_q;
  assign brk_irq  = irq_q;
endmodule

// File: rtl/bus_break_matcher_chk.sv
module bus_break_matcher_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_sel,
  input logic       clr_bit,
  input logic       cyc_valid,
  input logic       cyc_fetch,
  input logic [7:0] ctl,
  input logic       brk_flag,
  input logic       brk_irq
);
  p_irq_with_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> brk_flag);

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |=> !brk_irq);

  p_irq_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> $past(cyc_valid));

  p_irq_needs_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> $past(ctl[7:6] != 2'b00 && ctl[5:4] != 2'b00 && ctl[3:2] != 2'b00));

  p_no_byte_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> !$past(cyc_fetch && ctl[1:0] == 2'b01));

  p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_flag) |-> brk_irq);

  p_flag_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_flag) |-> $past(reg_we && reg_sel == 2'd3 && !clr_bit));
endmodule

bind bus_break_matcher bus_break_matcher_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_we   (reg_we),
  .reg_sel  (reg_sel),
  .clr_bit  (reg_wdata[0]),
  .cyc_valid(cyc_valid),
  .cyc_fetch(cyc_fetch),
  .ctl      (ctl_q),
  .brk_flag (brk_flag),
  .brk_irq  (brk_irq)
);

// File: tb/bus_break_matcher_tb.sv
module bus_break_matcher_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        cyc_valid = 1'b0, cyc_periph = 1'b0, cyc_fetch = 1'b0, cyc_write = 1'b0;
  logic [1:0]  cyc_size = 2'b01;
  logic [31:0] cyc_addr = '0;
  logic        brk_flag, brk_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_req = "R1";

  bus_break_matcher u_dut (.*);

  always #2 clk = ~clk;

  // behavioural reference
  int unsigned m_ctl, m_cmp, m_msk;
  bit m_flag, m_irq;

  function automatic bit model_hit();
    int sz;
    bit ok;
    if (!cyc_valid) return 0;
    case (cyc_periph)
      1'b0: ok = (m_ctl >> 6) % 2 == 1;
      1'b1: ok = (m_ctl >> 7) % 2 == 1;
    endcase
    if (!ok) return 0;
    if (cyc_fetch) ok = (m_ctl >> 4) % 2 == 1;
    else           ok = (m_ctl >> 5) % 2 == 1;
    if (!ok) return 0;
    if (cyc_write) ok = (m_ctl >> 3) % 2 == 1;
    else           ok = (m_ctl >> 2) % 2 == 1;
    if (!ok) return 0;
    sz = cyc_fetch ? 2 : int'(cyc_size);
    if (m_ctl % 4 != 0 && m_ctl % 4 != sz) return 0;
    for (int b = 0; b < 32; b++)
      if (!m_msk[b] && (cyc_addr[b] != m_cmp[b])) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    bit h;
    if (!rst_n) begin
      m_ctl <= 0; m_cmp <= 0; m_msk <= 0; m_flag <= 0; m_irq <= 0;
    end else begin
      h = model_hit();
      m_irq <= h && !m_flag;
      if (h) m_flag <= 1;
      else if (reg_we && reg_sel == 3 && reg_wdata[0] == 0) m_flag <= 0;
      if (reg_we) begin
        if (reg_sel == 0) m_ctl <= reg_wdata & 32'hFF;
        if (reg_sel == 1) m_cmp <= reg_wdata;
        if (reg_sel == 2) m_msk <= reg_wdata;
      end
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check(cur_req, "brk_irq", brk_irq, m_irq);
    check(cur_req, "brk_flag", brk_flag, m_flag);
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic cyc(input bit p, input bit f, input bit w, input logic [1:0] sz,
                     input logic [31:0] a, input bit v = 1);
    @(negedge clk);
    cyc_valid = v; cyc_periph = p; cyc_fetch = f; cyc_write = w; cyc_size = sz; cyc_addr = a;
    @(negedge clk);
    cyc_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", "reset flag", brk_flag, 1'b0);
    check("R1", "reset irq", brk_irq, 1'b0);
    cyc(0, 0, 0, 2'b01, 32'h0);
    cyc(1, 1, 1, 2'b11, 32'h0);
    check("R1", "idle after reset", brk_flag, 1'b0);

    // sweep every condition byte against every attribute combination
    cur_req = "R2";
    wr(2, 32'hFFFF_FFFF);
    for (int c = 0; c < 256; c++) begin
      if (c == 64) cur_req = "R3";
      if (c == 128) cur_req = "R4";
      if (c == 192) cur_req = "R5";
      wr(0, c);
      for (int k = 0; k < 32; k++) begin
        cyc(k[4], k[3], k[2], k[1:0], 32'h1234_5678);
        if (brk_flag) wr(3, 0);
      end
    end

    cur_req = "R6";
    wr(0, 8'b01_01_01_01);
    cyc(0, 1, 0, 2'b01, 0);
    check("R6", "byte-select fetch", brk_flag, 1'b0);
    wr(0, 8'b01_01_01_10);
    cyc(0, 1, 0, 2'b11, 0);
    check("R6", "fetch counts as word", brk_flag, 1'b1);
    wr(3, 0);

    cur_req = "R7";
    wr(0, 8'hFC);
    wr(1, 32'hA5A5_0000);
    wr(2, 32'h0000_FFFF);
    cyc(0, 0, 0, 2'b01, 32'hA5A5_BEEF);
    check("R7", "masked low bits", brk_flag, 1'b1);
    wr(3, 0);
    cyc(0, 0, 0, 2'b01, 32'hA5A4_0000);
    check("R7", "unmasked mismatch", brk_flag, 1'b0);
    wr(2, 0);
    cyc(0, 0, 0, 2'b01, 32'hA5A5_0001);
    check("R7", "full compare bit0", brk_flag, 1'b0);
    cyc(0, 0, 0, 2'b01, 32'hA5A5_0000);
    check("R7", "full compare exact", brk_flag, 1'b1);
    wr(3, 0);

    cur_req = "R8";
    cyc(0, 0, 0, 2'b01, 32'hA5A5_0000, 0);
    check("R8", "strobe low ignored", brk_flag, 1'b0);

    cur_req = "R9";
    cyc(0, 0, 0, 2'b01, 32'hA5A5_0000);
    cyc(0, 0, 0, 2'b01, 32'hA5A5_0000);
    check("R9", "no second pulse", brk_irq, 1'b0);
    check("R9", "flag held", brk_flag, 1'b1);

    cur_req = "R10";
    wr(3, 1);
    check("R10", "write 1 keeps flag", brk_flag, 1'b1);
    @(negedge clk);
    reg_we = 1; reg_sel = 3; reg_wdata = 0;
    cyc_valid = 1; cyc_periph = 0; cyc_fetch = 0; cyc_write = 0; cyc_size = 2'b01;
    cyc_addr = 32'hA5A5_0000;
    @(negedge clk);
    reg_we = 0; cyc_valid = 0;
    check("R10", "match beats clear", brk_flag, 1'b1);
    wr(3, 0);
    check("R10", "cleared", brk_flag, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule